// File: doc/BRIEF.md
# Storage Serialization Drain Controller

This controller sits between an in-order CPU pipeline and a posted store buffer. It watches decoded instructions and interruption requests. When a serializing event arrives, it holds back later storage accesses until every earlier CPU store and page-description update has retired. The work runs in three phases:

1. **Drain.** Earlier stores and page-description writes are drained.
2. **Execute.** The serializing operation itself runs. Its one-cycle start pulse is given by the controller.
3. **Final drain.** The operation's own result stores are drained.

Only after the final drain may fetch and operand access for later instructions resume. Channel-initiated accesses never pass through this block and are never stalled by it.

The drain policy depends on the kind of event:

- **Load-PSW:** its operand fetch may go ahead while the first drain is still running.
- **Interruption:** it may write its interruption code and associated fields during the first drain.
- **Any other serializing instruction:** all later accesses stay stalled.

Decoded instructions and interruption requests enter through two valid/ready handshakes.

- An item is taken on a clock edge where both valid and ready are high.
- A source seeing ready low must hold its valid and data stable.
- Interruptions win: while `irq_valid` is high, `dec_ready` is low.
- A one-entry pending slot holds a second serializing event that arrives while one is in progress. While that slot is full, both ready signals are low.
- Non-serializing instructions are accepted with no effect, including earlier instructions still in flight while a serialization is in progress.

Top module: `serial_drain_ctrl`

## Requirements
- R1: After reset, `fetch_stall`, `operand_stall`, `drain_req`, `exec_go` and `busy` are 0, and `dec_ready` and `irq_ready` are 1.
- R2: An accepted decoded instruction is serializing when any of these holds:
  - `dec_ser_op` is 1;
  - `dec_lpsw` is 1;
  - `dec_bcr` is 1 with `dec_mask` all ones and `dec_reg` all zeros.

  A branch with any other mask or register value has no effect: `fetch_stall` and `busy` stay 0.
- R3: `fetch_stall` goes to 1 in the cycle a serializing event is accepted. In the following drain phase `drain_req` is 1, and for an ordinary serializing instruction `operand_stall` is 1. The drain phase lasts while `sb_count` is nonzero.
- R4: `exec_go` is 1 for exactly one cycle: the cycle in the drain phase when `sb_count` is 0 and `pgd_pending` is 0. In the following execute phase `operand_stall` and `drain_req` are 0 and `fetch_stall` stays 1 until `exec_done`.
- R5: The cycle after `exec_done`, `drain_req`, `fetch_stall` and `operand_stall` are 1. They stay 1 until `sb_count` is 0 and `pgd_pending` is 0. If nothing is pending, all stalls and `busy` drop on the next cycle.
- R6: For a load-PSW event, `operand_stall` is 0 during the first drain phase, while `fetch_stall` and `drain_req` are 1.
- R7: An interruption is accepted through `irq_valid`/`irq_ready`. During its first drain phase `operand_stall` is 0, so the code fields can be written. While `irq_valid` is 1, `dec_ready` is 0.
- R8: A serializing event accepted while another is in progress is held. While it is held, `dec_ready` and `irq_ready` are 0. It starts its own drain phase directly when the current one releases, and `fetch_stall` stays 1 across the handover.
- R9: A nonzero `pgd_pending` keeps the drain phase from ending even when `sb_count` is 0.
- R10: `fetch_stall` is 1 in every cycle from acceptance of a serializing event until its release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decoded instruction offered |
| dec_ready | output | 1 | Decoded instruction can be taken |
| dec_ser_op | input | 1 | Opcode is in the always-serializing class |
| dec_bcr | input | 1 | Instruction is the register form of branch-on-condition |
| dec_mask | input | MASK_W | Branch mask field |
| dec_reg | input | REG_W | Branch register field |
| dec_lpsw | input | 1 | Instruction is load-PSW |
| irq_valid | input | 1 | Interruption requested |
| irq_ready | output | 1 | Interruption can be taken |
| sb_count | input | CNT_W | Store-buffer outstanding entries |
| pgd_pending | input | 1 | A page-description write is outstanding |
| exec_done | input | 1 | Serializing operation finished executing |
| fetch_stall | output | 1 | Hold instruction fetch |
| operand_stall | output | 1 | Hold operand access |
| drain_req | output | 1 | Ask the store buffer to drain |
| exec_go | output | 1 | One-cycle start of the execute phase |
| busy | output | 1 | A serialization is active or pending |

## Verification
The classifier is tried with three branch encodings. Only a full mask with a zero register field serializes, so these cases separate a correct match from a check on only one of the two fields.

Ordinary, load-PSW and interruption events are each driven through all three phases with stores outstanding. This shows whether operand stalling follows the event kind while fetch stays held.

A second event is queued behind the first, which tests that the handover keeps fetch stalled and that both ready signals drop while the slot is full. A page-description write left outstanding with an empty store buffer tests that both drain conditions are required.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [1:0] {
    K_PLAIN = 2'd0,
    K_LPSW  = 2'd1,
    K_IRQ   = 2'd2
  } ser_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DRAIN = 2'd1,
    PH_EXEC  = 2'd2,
    PH_FINAL = 2'd3
  } ser_phase_e;
endpackage

// File: rtl/ser_classify.sv
module ser_classify
  import ser_pkg::*;
#(
  parameter int MASK_W = 4,
  parameter int REG_W  = 4
) (
  input  logic              ser_op,
  input  logic              bcr,
  input  logic [MASK_W-1:0] mask,
  input  logic [REG_W-1:0]  rfield,
  input  logic              lpsw,
  output logic              is_ser,
  output ser_kind_e         kind
);
  localparam logic [MASK_W-1:0] FULL_MASK = {MASK_W{1'b1}};
  localparam logic [REG_W-1:0]  ZERO_REG  = '0;

  logic bcr_fence;

  // R2: only the all-ones mask with register field zero acts as a fence
  always_comb begin
    bcr_fence = bcr && (mask == FULL_MASK) && (rfield == ZERO_REG);
    is_ser    = ser_op || lpsw || bcr_fence;
    kind      = lpsw ? K_LPSW : K_PLAIN;
  end
endmodule

// File: rtl/ser_pending.sv
module ser_pending
  import ser_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  ser_kind_e load_kind,
  input  logic      take,
  output logic      valid,
  output ser_kind_e kind
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      kind  <= K_PLAIN;
    end else if (load) begin
      valid <= 1'b1;
      kind  <= load_kind;
    end else if (take) begin
      valid <= 1'b0;
    end
  end

  // R8
  pend_no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !take) |-> !load);

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !take) |=> (valid && $stable(kind)));
endmodule

// File: rtl/ser_phase_fsm.sv
module ser_phase_fsm
  import ser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  ser_kind_e  start_kind,
  input  logic       pend_valid,
  input  ser_kind_e  pend_kind,
  input  logic       drain_done,
  input  logic       exec_done,
  output ser_phase_e phase,
  output ser_kind_e  cur_kind,
  output logic       exec_go,
  output logic       take_pend
);
  ser_phase_e phase_n;
  ser_kind_e  kind_n;

  always_comb begin
    phase_n   = phase;
    kind_n    = cur_kind;
    exec_go   = 1'b0;
    take_pend = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          phase_n = PH_DRAIN;
          kind_n  = start_kind;
        end else if (pend_valid) begin
          phase_n   = PH_DRAIN;
          kind_n    = pend_kind;
          take_pend = 1'b1;
        end
      end
      PH_DRAIN: begin
        if (drain_done) begin
          exec_go = 1'b1;
          phase_n = PH_EXEC;
        end
      end
      PH_EXEC: begin
        if (exec_done) phase_n = PH_FINAL;
      end
      PH_FINAL: begin
        if (drain_done) begin
          if (pend_valid) begin
            phase_n   = PH_DRAIN;
            kind_n    = pend_kind;
            take_pend = 1'b1;
          end else begin
            phase_n = PH_IDLE;
          end
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cur_kind <= K_PLAIN;
    end else begin
      phase    <= phase_n;
      cur_kind <= kind_n;
    end
  end

  // R4
  exec_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |=> !exec_go);

  // R4
  exec_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && $past(phase) != PH_EXEC) |-> $past(exec_go));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && $past(phase) == PH_FINAL) |-> $past(drain_done));
endmodule

// File: rtl/serial_drain_ctrl.sv
module serial_drain_ctrl
  import ser_pkg::*;
#(
  parameter int MASK_W = 4,
  parameter int REG_W  = 4,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  output logic              dec_ready,
  input  logic              dec_ser_op,
  input  logic              dec_bcr,
  input  logic [MASK_W-1:0] dec_mask,
  input  logic [REG_W-1:0]  dec_reg,
  input  logic              dec_lpsw,
  input  logic              irq_valid,
  output logic              irq_ready,
  input  logic [CNT_W-1:0]  sb_count,
  input  logic              pgd_pending,
  input  logic              exec_done,
  output logic              fetch_stall,
  output logic              operand_stall,
  output logic              drain_req,
  output logic              exec_go,
  output logic              busy
);
  localparam logic [CNT_W-1:0] EMPTY = '0;

  logic       cls_ser;
  ser_kind_e  cls_kind;
  logic       pend_valid, take_pend, pend_load;
  ser_kind_e  pend_kind;
  ser_phase_e phase;
  ser_kind_e  cur_kind;
  logic       acc_irq, acc_dec, evt, start, drain_done;
  ser_kind_e  evt_kind;

  ser_classify #(.MASK_W(MASK_W), .REG_W(REG_W)) u_cls (
    .ser_op (dec_ser_op),
    .bcr    (dec_bcr),
    .mask   (dec_mask),
    .rfield (dec_reg),
    .lpsw   (dec_lpsw),
    .is_ser (cls_ser),
    .kind   (cls_kind)
  );

  always_comb begin
    irq_ready  = !pend_valid;
    dec_ready  = !pend_valid && !irq_valid;
    acc_irq    = irq_valid && irq_ready;
    acc_dec    = dec_valid && dec_ready && cls_ser;
    evt        = acc_irq || acc_dec;
    evt_kind   = acc_irq ? K_IRQ : cls_kind;
    start      = evt && (phase == PH_IDLE) && !pend_valid;
    pend_load  = evt && !start;
    drain_done = (sb_count == EMPTY) && !pgd_pending;
  end

  ser_pending u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (pend_load),
    .load_kind (evt_kind),
    .take      (take_pend),
    .valid     (pend_valid),
    .kind      (pend_kind)
  );

  ser_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_kind (evt_kind),
    .pend_valid (pend_valid),
    .pend_kind  (pend_kind),
    .drain_done (drain_done),
    .exec_done  (exec_done),
    .phase      (phase),
    .cur_kind   (cur_kind),
    .exec_go    (exec_go),
    .take_pend  (take_pend)
  );

  always_comb begin
    busy        = (phase != PH_IDLE) || pend_valid;
    fetch_stall = busy || evt;
    drain_req   = (phase == PH_DRAIN) || (phase == PH_FINAL);
    unique case (phase)
      PH_IDLE:  operand_stall = start && (evt_kind == K_PLAIN);
      PH_DRAIN: operand_stall = (cur_kind == K_PLAIN);
      PH_EXEC:  operand_stall = 1'b0;
      PH_FINAL: operand_stall = 1'b1;
      default:  operand_stall = 1'b1;
    endcase
  end

  // R3
  no_fetch_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DRAIN && sb_count != EMPTY) |-> (fetch_stall && drain_req && !exec_go));

  // R9
  pgd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DRAIN && pgd_pending) |=> (phase == PH_DRAIN));

  // R10
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> fetch_stall);

  // R8
  pend_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (!dec_ready && !irq_ready));
endmodule

// File: tb/tb_serial_drain_ctrl.sv
module tb_serial_drain_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MASK_W = 4;
  localparam int REG_W  = 4;
  localparam int CNT_W  = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic dec_valid, dec_ready, dec_ser_op, dec_bcr, dec_lpsw;
  logic [MASK_W-1:0] dec_mask;
  logic [REG_W-1:0]  dec_reg;
  logic irq_valid, irq_ready;
  logic [CNT_W-1:0] sb_count;
  logic pgd_pending, exec_done;
  logic fetch_stall, operand_stall, drain_req, exec_go, busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_drain_ctrl #(.MASK_W(MASK_W), .REG_W(REG_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_ser_op(dec_ser_op),
    .dec_bcr(dec_bcr), .dec_mask(dec_mask), .dec_reg(dec_reg), .dec_lpsw(dec_lpsw),
    .irq_valid(irq_valid), .irq_ready(irq_ready),
    .sb_count(sb_count), .pgd_pending(pgd_pending), .exec_done(exec_done),
    .fetch_stall(fetch_stall), .operand_stall(operand_stall),
    .drain_req(drain_req), .exec_go(exec_go), .busy(busy)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic clear_dec();
    dec_valid = 0; dec_ser_op = 0; dec_bcr = 0; dec_lpsw = 0;
    dec_mask = '0; dec_reg = '0;
  endtask

  // from execute phase with empty buffer: finish op and expect idle
  task automatic finish_op(input string req);
    exec_done = 1; sb_count = 0;
    step();
    exec_done = 0; #1;
    chk(req, "final drain_req", drain_req, 1'b1);
    chk(req, "final operand_stall", operand_stall, 1'b1);
    step();
    chk(req, "released fetch_stall", fetch_stall, 1'b0);
    chk(req, "released busy", busy, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1", "fetch_stall", fetch_stall, 1'b0);
    chk("R1", "operand_stall", operand_stall, 1'b0);
    chk("R1", "drain_req", drain_req, 1'b0);
    chk("R1", "exec_go", exec_go, 1'b0);
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "dec_ready", dec_ready, 1'b1);
    chk("R1", "irq_ready", irq_ready, 1'b1);
  endtask

  task automatic t_branch();
    dec_valid = 1; dec_bcr = 1; dec_mask = 4'hE; dec_reg = 4'h0; #1;
    chk("R2", "mask E fetch_stall", fetch_stall, 1'b0);
    step();
    chk("R2", "mask E busy", busy, 1'b0);
    dec_mask = 4'hF; dec_reg = 4'h1; #1;
    chk("R2", "reg 1 fetch_stall", fetch_stall, 1'b0);
    step();
    chk("R2", "reg 1 busy", busy, 1'b0);
    dec_mask = 4'hF; dec_reg = 4'h0; sb_count = 0; #1;
    chk("R2", "fence fetch_stall", fetch_stall, 1'b1);
    step();
    clear_dec(); #1;
    chk("R2", "fence busy", busy, 1'b1);
    chk("R4", "immediate exec_go", exec_go, 1'b1);
    step();
    finish_op("R2");
  endtask

  task automatic t_plain();
    sb_count = 3; dec_valid = 1; dec_ser_op = 1; #1;
    chk("R3", "accept-cycle fetch_stall", fetch_stall, 1'b1);
    step();
    clear_dec(); #1;
    chk("R3", "drain drain_req", drain_req, 1'b1);
    chk("R3", "drain operand_stall", operand_stall, 1'b1);
    chk("R3", "drain exec_go", exec_go, 1'b0);
    step();
    chk("R10", "still draining fetch_stall", fetch_stall, 1'b1);
    chk("R3", "still draining exec_go", exec_go, 1'b0);
    sb_count = 0; #1;
    chk("R4", "exec_go on empty", exec_go, 1'b1);
    step();
    chk("R4", "exec exec_go low", exec_go, 1'b0);
    chk("R4", "exec operand_stall", operand_stall, 1'b0);
    chk("R4", "exec drain_req", drain_req, 1'b0);
    chk("R4", "exec fetch_stall", fetch_stall, 1'b1);
    step();
    chk("R10", "exec hold fetch_stall", fetch_stall, 1'b1);
    exec_done = 1; sb_count = 2;
    step();
    exec_done = 0; #1;
    chk("R5", "final drain_req", drain_req, 1'b1);
    chk("R5", "final fetch_stall", fetch_stall, 1'b1);
    step();
    chk("R5", "final held operand_stall", operand_stall, 1'b1);
    sb_count = 0;
    step();
    chk("R5", "release fetch_stall", fetch_stall, 1'b0);
    chk("R5", "release operand_stall", operand_stall, 1'b0);
    chk("R5", "release busy", busy, 1'b0);
  endtask

  task automatic t_lpsw();
    sb_count = 2; dec_valid = 1; dec_lpsw = 1;
    step();
    clear_dec(); #1;
    chk("R6", "lpsw operand_stall", operand_stall, 1'b0);
    chk("R6", "lpsw fetch_stall", fetch_stall, 1'b1);
    chk("R6", "lpsw drain_req", drain_req, 1'b1);
    sb_count = 0; #1;
    chk("R6", "lpsw exec_go", exec_go, 1'b1);
    step();
    finish_op("R6");
  endtask

  task automatic t_irq();
    sb_count = 4; irq_valid = 1; dec_valid = 1; dec_ser_op = 1; #1;
    chk("R7", "dec_ready with irq", dec_ready, 1'b0);
    chk("R7", "irq_ready", irq_ready, 1'b1);
    step();
    irq_valid = 0; clear_dec(); #1;
    chk("R7", "irq operand_stall", operand_stall, 1'b0);
    chk("R7", "irq drain_req", drain_req, 1'b1);
    step();
    chk("R7", "decode not queued", dec_ready, 1'b1);
    sb_count = 0; #1;
    chk("R7", "irq exec_go", exec_go, 1'b1);
    step();
    finish_op("R7");
  endtask

  task automatic t_pending();
    sb_count = 1; dec_valid = 1; dec_ser_op = 1;
    step();
    clear_dec(); irq_valid = 1; #1;
    chk("R8", "irq_ready while busy", irq_ready, 1'b1);
    step();
    irq_valid = 0; dec_valid = 1; dec_ser_op = 1; #1;
    chk("R8", "dec_ready slot full", dec_ready, 1'b0);
    chk("R8", "irq_ready slot full", irq_ready, 1'b0);
    step();
    clear_dec(); sb_count = 0; #1;
    chk("R8", "first exec_go", exec_go, 1'b1);
    step();
    exec_done = 1;
    step();
    exec_done = 0; #1;
    chk("R8", "first final drain_req", drain_req, 1'b1);
    step();
    chk("R8", "handover fetch_stall", fetch_stall, 1'b1);
    chk("R8", "handover drain_req", drain_req, 1'b1);
    chk("R8", "handover irq operand_stall", operand_stall, 1'b0);
    chk("R8", "handover exec_go", exec_go, 1'b1);
    chk("R8", "slot freed dec_ready", dec_ready, 1'b1);
    step();
    finish_op("R8");
  endtask

  task automatic t_pgd();
    sb_count = 0; pgd_pending = 1; dec_valid = 1; dec_ser_op = 1;
    step();
    clear_dec(); #1;
    chk("R9", "pgd blocks exec_go", exec_go, 1'b0);
    step();
    chk("R9", "pgd still blocks", exec_go, 1'b0);
    chk("R9", "pgd drain_req", drain_req, 1'b1);
    pgd_pending = 0; #1;
    chk("R9", "pgd clear exec_go", exec_go, 1'b1);
    step();
    finish_op("R9");
  endtask

  initial begin
    rst_n = 0; clear_dec(); irq_valid = 0; sb_count = 0; pgd_pending = 0; exec_done = 0;
    step(); step();
    rst_n = 1; #1;
    t_reset();
    step();
    t_branch();
    t_plain();
    t_lpsw();
    t_irq();
    t_pending();
    t_pgd();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule